// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the command engine of an SD host controller. Software loads a 32-bit argument, then writes a 16-bit command word. When that word carries the start flag, the unit places the 6-bit command index and the argument on a card-side request port. The port uses a valid/ready handshake. The unit then waits for one response beat and checks the response length against the flags in the command word. A good response is stored as four 32-bit words, and a bad one is flagged both in the command word and in the host status register.

The control is a three-state machine. `ST_IDLE` goes to `ST_ISSUE` on a start write. `ST_ISSUE` holds the request valid and moves to `ST_WAIT` when the card accepts it. `ST_WAIT` returns to `ST_IDLE` when the response beat arrives, and that transition is the completion point. The status register is write-1-to-clear, and its three interrupt-class bits are ORed onto a single interrupt line. Clocking, CRC and serial signalling on the SD lines are handled elsewhere.

Top module: `sdh_cmd_issue`

## Requirements
- R1: After reset, the command, argument, config, status and all four response words read 0, and `irq` is low.
- R2: A write of the command word (offset 0x00) with bit 15 set, while idle, issues exactly one request. The request carries index = command bits 5:0 and the current argument (offset 0x04), and it stays valid and stable until `req_ready`. A command write with bit 15 clear only stores the value.
- R3: At completion, command bit 15 reads 0 and every other written bit is kept.
- R4: Response length code 1 is 4 bytes. Byte k of `rsp_data` sits at bits [127-8k -: 8]. Word 0 (0x10) becomes bytes 0..3 with byte 0 as the most significant byte, and words 1..3 (0x14, 0x18, 0x1C) are cleared.
- R5: Length code 2 is 16 bytes. Word 0 gets bytes 12..15, word 1 gets bytes 8..11, word 2 gets bytes 4..7 and word 3 gets bytes 0..3, each big-endian.
- R6: A command fails when `rsp_err` is set. When command bit 10 (no-response) is clear, it also fails on length code 0, on code 3 (any other length), or on code 1 with bit 9 (long) set. A failure sets command bit 14 and status bit 6 (0x040) and leaves the response words unchanged.
- R7: With command bit 10 set, the response length is ignored and the response words are unchanged.
- R8: A successful command with bit 11 (busy-wait) set, while config (0x38) bit 10 is set, sets status bit 10 (0x400). A failed command or a clear enable leaves bit 10 alone.
- R9: Writing the status register (0x20) clears exactly the bits written as 1.
- R10: `irq` is high exactly when any of status bits 10, 9 or 8 is set.
- R11: While a command is pending, writes to the command word and the argument are ignored.
- R12: An offset that is not mapped reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Card request valid |
| req_ready | input | 1 | Card accepts request |
| req_index | output | 6 | Command index of request |
| req_arg | output | 32 | Argument of request |
| rsp_valid | input | 1 | Response beat from card |
| rsp_err | input | 1 | Card reports command error |
| rsp_len | input | 2 | Length code: 0 none, 1 four bytes, 2 sixteen bytes, 3 other |
| rsp_data | input | 128 | Response bytes, byte 0 in the top bits |
| irq | output | 1 | Interrupt, OR of status bits 10..8 |

## Verification
The bench sends a 4-byte reply to a long-response command, and also replies of length code 0 and code 3. A design that checked only the card error flag would accept these and overwrite the stored words, where a correct design flags a failure and keeps them. It checks the 16-byte word order against known byte patterns, so a design that failed to reverse the words would show the wrong word 0. It starts a second command while one is pending and issues busy-wait commands with the enable off and on, and with a card error. A design that queued the second start, or raised the busy bit unconditionally or after a failure, would either produce an unexpected request or show a wrong status and interrupt.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } cmd_state_t;

    localparam int WORD_W    = 32;
    localparam int RSP_WORDS = 4;
    localparam int RSP_BITS  = WORD_W * RSP_WORDS;
    localparam int CMD_W     = 16;
    localparam int STAT_W    = 11;
    localparam int CFG_W     = 11;
    localparam int IDX_W     = 6;

    localparam logic [1:0] LEN_NONE  = 2'd0;
    localparam logic [1:0] LEN_SHORT = 2'd1;
    localparam logic [1:0] LEN_LONG  = 2'd2;

    localparam int CB_START = 15;
    localparam int CB_FAIL  = 14;
    localparam int CB_BUSYW = 11;
    localparam int CB_NORSP = 10;
    localparam int CB_LONG  = 9;

    localparam int SB_TOUT  = 6;
    localparam int SB_BUSY  = 10;
    localparam int CF_BUSY_EN = 10;

    localparam int OFF_CMD  = 'h00;
    localparam int OFF_ARG  = 'h04;
    localparam int OFF_RSP0 = 'h10;
    localparam int OFF_STAT = 'h20;
    localparam int OFF_CFG  = 'h38;
endpackage

// File: rtl/sdh_cmd_fsm.sv
module sdh_cmd_fsm
    import sdh_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       req_ready,
    input  logic       rsp_valid,
    output cmd_state_t state,
    output logic       req_valid,
    output logic       done
);
    cmd_state_t state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  if (start)     state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        req_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: req_valid = 1'b1;
            ST_WAIT:  done = rsp_valid;
            default:  ;
        endcase
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid);

    // R2
    req_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(start));
endmodule

// File: rtl/sdh_rsp_check.sv
module sdh_rsp_check
    import sdh_cmd_pkg::*;
(
    input  logic                               no_rsp,
    input  logic                               long_rsp,
    input  logic                               err,
    input  logic [1:0]                         len,
    input  logic [RSP_BITS-1:0]                data,
    output logic                               fail,
    output logic                               store,
    output logic [RSP_WORDS-1:0][WORD_W-1:0]   words
);
    logic bad_len;

    always_comb begin
        bad_len = !((len == LEN_SHORT && !long_rsp) || len == LEN_LONG);
        fail    = err || (!no_rsp && bad_len);
        store   = !fail && !no_rsp;
    end

    for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
        if (i == 0) begin : g_first
            assign words[i] = (len == LEN_LONG) ? data[WORD_W*i +: WORD_W]
                                                : data[RSP_BITS-1 -: WORD_W];
        end else begin : g_rest
            assign words[i] = (len == LEN_LONG) ? data[WORD_W*i +: WORD_W]
                                                : '0;
        end
    end
endmodule

// File: rtl/sdh_status_reg.sv
module sdh_status_reg
    import sdh_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic              set_tout,
    input  logic              set_busy,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] status_d;

    always_comb begin
        status_d = status & ~clr_mask;
        if (set_tout) status_d[SB_TOUT] = 1'b1;
        if (set_busy) status_d[SB_BUSY] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_d;
            irq    <= |status_d[SB_BUSY:8];
        end
    end

    // R10
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|status[SB_BUSY:8]));

    // R8
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_busy |=> status[SB_BUSY]);
endmodule

// File: rtl/sdh_cmd_issue.sv
module sdh_cmd_issue
    import sdh_cmd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [IDX_W-1:0]    req_index,
    output logic [WORD_W-1:0]   req_arg,
    input  logic                rsp_valid,
    input  logic                rsp_err,
    input  logic [1:0]          rsp_len,
    input  logic [RSP_BITS-1:0] rsp_data,
    output logic                irq
);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(OFF_ARG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);

    logic [CMD_W-1:0]                cmd_q;
    logic [WORD_W-1:0]               arg_q;
    logic [CFG_W-1:0]                cfg_q;
    logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_q;
    logic [RSP_WORDS-1:0][WORD_W-1:0] chk_words;
    logic [STAT_W-1:0]               status;
    cmd_state_t                      state;
    logic busy, start, done, chk_fail, chk_store;
    logic wr_cmd, wr_arg, wr_stat, wr_cfg;
    logic unused_wdata;

    assign unused_wdata = ^wr_data[WORD_W-1:CMD_W];

    assign busy    = (state != ST_IDLE);
    assign wr_cmd  = wr_en && (wr_addr == A_CMD);
    assign wr_arg  = wr_en && (wr_addr == A_ARG);
    assign wr_stat = wr_en && (wr_addr == A_STAT);
    assign wr_cfg  = wr_en && (wr_addr == A_CFG);
    assign start   = wr_cmd && !busy && wr_data[CB_START];

    sdh_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .state     (state),
        .req_valid (req_valid),
        .done      (done)
    );

    sdh_rsp_check u_chk (
        .no_rsp   (cmd_q[CB_NORSP]),
        .long_rsp (cmd_q[CB_LONG]),
        .err      (rsp_err),
        .len      (rsp_len),
        .data     (rsp_data),
        .fail     (chk_fail),
        .store    (chk_store),
        .words    (chk_words)
    );

    sdh_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (wr_stat ? wr_data[STAT_W-1:0] : '0),
        .set_tout (done && chk_fail),
        .set_busy (done && !chk_fail && cmd_q[CB_BUSYW] && cfg_q[CF_BUSY_EN]),
        .status   (status),
        .irq      (irq)
    );

    assign req_index = cmd_q[IDX_W-1:0];
    assign req_arg   = arg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            arg_q <= '0;
            cfg_q <= '0;
            rsp_q <= '0;
        end else begin
            if (wr_cmd && !busy) begin
                cmd_q <= wr_data[CMD_W-1:0];
            end else if (done) begin
                cmd_q[CB_START] <= 1'b0;
                if (chk_fail) cmd_q[CB_FAIL] <= 1'b1;
            end
            if (wr_arg && !busy) arg_q <= wr_data;
            if (wr_cfg)          cfg_q <= wr_data[CFG_W-1:0];
            if (done && chk_store) rsp_q <= chk_words;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CMD:  rd_data = WORD_W'(cmd_q);
            A_ARG:  rd_data = arg_q;
            A_STAT: rd_data = WORD_W'(status);
            A_CFG:  rd_data = WORD_W'(cfg_q);
            default: begin
                for (int i = 0; i < RSP_WORDS; i++) begin
                    if (rd_addr == ADDR_W'(OFF_RSP0 + 4 * i)) rd_data = rsp_q[i];
                end
            end
        endcase
    end

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cmd_q[CB_START]);

    // R6
    fail_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chk_fail) |=> (cmd_q[CB_FAIL] && status[SB_TOUT] && $stable(rsp_q)));

    // R7
    norsp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q[CB_NORSP]) |=> $stable(rsp_q));

    // R11
    pending_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_en) |=> ($stable(cmd_q) && $stable(arg_q)));
endmodule

// File: tb/sdh_cmd_issue_tb.sv
module sdh_cmd_issue_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [7:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic         req_valid;
    logic         req_ready = 1'b0;
    logic [5:0]   req_index;
    logic [31:0]  req_arg;
    logic         rsp_valid = 1'b0;
    logic         rsp_err = 1'b0;
    logic [1:0]   rsp_len = '0;
    logic [127:0] rsp_data = '0;
    logic         irq;

    int checks = 0;
    int errors = 0;

    logic [1:0]   card_len = 0;
    logic [127:0] card_data = '0;
    logic         card_err = 0;
    int           card_stall = 0;
    logic [37:0]  exp_req[$];

    always #2.5 clk = ~clk;

    sdh_cmd_issue dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_index(req_index),
        .req_arg(req_arg), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_len(rsp_len), .rsp_data(rsp_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        reg_rd(a, v);
        check(req, v, exp);
    endtask

    // Card model and request monitor: pops the scoreboard at each handshake.
    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                repeat (card_stall) @(negedge clk);
                checks++;
                if (exp_req.size() == 0) begin
                    errors++;
                    $display("FAIL R2/R11: actual unexpected request %h expected none",
                             {req_index, req_arg});
                end else begin
                    logic [37:0] e;
                    e = exp_req.pop_front();
                    if ({req_index, req_arg} !== e) begin
                        errors++;
                        $display("FAIL R2: actual %h expected %h", {req_index, req_arg}, e);
                    end
                end
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                repeat (2) @(negedge clk);
                rsp_valid = 1'b1; rsp_err = card_err;
                rsp_len = card_len; rsp_data = card_data;
                @(negedge clk);
                rsp_valid = 1'b0; rsp_err = 1'b0;
            end
        end
    end

    task automatic launch(input logic [15:0] cmd, input logic [31:0] arg,
                          input logic [1:0] len, input logic [127:0] data,
                          input logic err, input int stall);
        card_len = len; card_data = data; card_err = err; card_stall = stall;
        reg_wr(8'h04, arg);
        exp_req.push_back({cmd[5:0], arg});
        reg_wr(8'h00, {16'h0, cmd | 16'h8000});
    endtask

    task automatic wait_done();
        logic [31:0] v;
        int n = 0;
        do begin
            reg_rd(8'h00, v);
            n++;
        end while (v[15] && n < 100);
        if (v[15]) check("R3 completion", v, v & 32'hFFFF7FFF);
        repeat (2) @(negedge clk);
    endtask

    task automatic issue(input logic [15:0] cmd, input logic [31:0] arg,
                         input logic [1:0] len, input logic [127:0] data,
                         input logic err, input int stall);
        launch(cmd, arg, len, data, err, stall);
        wait_done();
    endtask

    localparam logic [127:0] PAT_A = 128'hDEADBEEF_01020304_05060708_090A0B0C;
    localparam logic [127:0] PAT_B = 128'h00112233_44556677_8899AABB_CCDDEEFF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check("R1 cmd", 8'h00, 0);
        rd_check("R1 arg", 8'h04, 0);
        rd_check("R1 cfg", 8'h38, 0);
        rd_check("R1 status", 8'h20, 0);
        for (int i = 0; i < 4; i++) rd_check("R1 rsp", 8'h10 + 8'(4 * i), 0);
        check("R1 irq", {31'h0, irq}, 0);

        // R4 short response, R2/R3 command readback
        issue(16'h0011, 32'h12345678, 2'd1, PAT_A, 1'b0, 0);
        rd_check("R4 word0", 8'h10, 32'hDEADBEEF);
        rd_check("R4 word1", 8'h14, 0);
        rd_check("R4 word2", 8'h18, 0);
        rd_check("R4 word3", 8'h1C, 0);
        rd_check("R3 cmd kept", 8'h00, 32'h0011);
        rd_check("R2 status ok", 8'h20, 0);

        // R5 long response with stalled ready
        issue(16'h0202, 32'hA5A5_0001, 2'd2, PAT_B, 1'b0, 3);
        rd_check("R5 word0", 8'h10, 32'hCCDDEEFF);
        rd_check("R5 word1", 8'h14, 32'h8899AABB);
        rd_check("R5 word2", 8'h18, 32'h44556677);
        rd_check("R5 word3", 8'h1C, 32'h00112233);
        rd_check("R3 cmd kept long", 8'h00, 32'h0202);

        // R6 long command with short reply
        issue(16'h0209, 32'h0, 2'd1, PAT_A, 1'b0, 0);
        rd_check("R6 cmd fail bit", 8'h00, 32'h4209);
        rd_check("R6 status tout", 8'h20, 32'h040);
        rd_check("R6 words kept", 8'h10, 32'hCCDDEEFF);
        check("R10 irq low on tout", {31'h0, irq}, 0);
        // R9 W1C
        reg_wr(8'h20, 32'h040);
        rd_check("R9 clear tout", 8'h20, 0);

        // R6 zero length and bad length
        issue(16'h0003, 32'h3, 2'd0, PAT_A, 1'b0, 0);
        rd_check("R6 len0 cmd", 8'h00, 32'h4003);
        rd_check("R6 len0 status", 8'h20, 32'h040);
        reg_wr(8'h20, 32'hFFFF);
        issue(16'h0004, 32'h4, 2'd3, PAT_A, 1'b0, 0);
        rd_check("R6 len3 cmd", 8'h00, 32'h4004);
        rd_check("R6 len3 word3", 8'h1C, 32'h00112233);
        reg_wr(8'h20, 32'h040);

        // R7 no-response commands
        issue(16'h0407, 32'h7, 2'd0, PAT_A, 1'b0, 0);
        rd_check("R7 cmd no fail", 8'h00, 32'h0407);
        rd_check("R7 status", 8'h20, 0);
        issue(16'h0406, 32'h6, 2'd2, PAT_A, 1'b0, 0);
        rd_check("R7 word0 kept", 8'h10, 32'hCCDDEEFF);
        rd_check("R7 word3 kept", 8'h1C, 32'h00112233);
        issue(16'h0408, 32'h8, 2'd0, PAT_A, 1'b1, 0);
        rd_check("R6 err fail", 8'h00, 32'h4408);
        reg_wr(8'h20, 32'h040);

        // R8 busy-wait without and with enable
        issue(16'h0C0D, 32'hD, 2'd0, PAT_A, 1'b0, 0);
        rd_check("R8 no enable", 8'h20, 0);
        check("R10 irq idle", {31'h0, irq}, 0);
        reg_wr(8'h38, 32'h400);
        rd_check("R12 cfg map", 8'h38, 32'h400);
        issue(16'h0C0E, 32'hE, 2'd0, PAT_A, 1'b0, 0);
        rd_check("R8 busy set", 8'h20, 32'h400);
        check("R10 irq on busy", {31'h0, irq}, 1);
        reg_wr(8'h20, 32'h040);
        rd_check("R9 other bits kept", 8'h20, 32'h400);
        reg_wr(8'h20, 32'h400);
        rd_check("R9 busy cleared", 8'h20, 0);
        @(negedge clk);
        check("R10 irq cleared", {31'h0, irq}, 0);
        issue(16'h0C0F, 32'hF, 2'd0, PAT_A, 1'b1, 0);
        rd_check("R8 no busy on fail", 8'h20, 32'h040);
        reg_wr(8'h20, 32'h040);

        // R2 command write without start
        reg_wr(8'h00, 32'h00C5);
        repeat (6) @(negedge clk);
        rd_check("R2 store only", 8'h00, 32'h00C5);

        // R11 writes while pending
        launch(16'h0011, 32'h0BAD_F00D, 2'd1, PAT_A, 1'b0, 6);
        reg_wr(8'h00, 32'h8005);
        reg_wr(8'h04, 32'hFFFF_FFFF);
        wait_done();
        rd_check("R11 cmd kept", 8'h00, 32'h0011);
        rd_check("R11 arg kept", 8'h04, 32'h0BAD_F00D);
        repeat (10) @(negedge clk);

        // R12 unmapped
        rd_check("R12 unmapped", 8'h08, 0);
        check("R2 queue drained", exp_req.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule